// File: doc/BRIEF.md
# Direct-Sequence Chip Spreader and Despreader

This block performs baseband direct-sequence spreading and despreading. A pseudo-noise chip stream comes from a maximal-length linear feedback shift register whose feedback is pure XOR. A short repeating data pattern is held for a whole number of chips per bit, and each chip leaves the block as the data bit XORed with the current PN chip.

The receive half runs its own copy of the same PN generator. It removes the code from the incoming chip stream by XORing again. It then decides each data bit by a majority vote over the despread chips that belong to that bit. Everything advances only on cycles where the chip-rate enable is high.

The two generators are aligned by the common reset. A receiver chip offset input delays the start of the receive generator by a chosen number of chips. The data only comes back intact when the offset is zero, so the input demonstrates the need for code alignment. Carrier handling and automatic code acquisition lie outside the block.

Top module: `dsss_codec`

## Requirements
- R1: While reset is low, `rx_valid` and `rx_bit` are 0 and `pn_chip` equals the most significant bit of the seed (default seed 5'b10011, so `pn_chip` is 1).
- R2: `pn_chip` is the most significant bit s[4] of a 5-bit register. On each enabled chip the register shifts toward its most significant bit and takes s[4] XOR s[2] into bit 0, which gives a sequence that repeats every 31 chips.
- R3: Any 31 consecutive PN chips taken from the start after reset contain exactly 16 ones.
- R4: A cycle with `chip_en` low changes neither `pn_chip` nor the transmit position, and `rx_valid` is 0 after that edge.
- R5: `pat_sel`=0 selects the repeating bits 1,0,0,0,0 and `pat_sel`=1 selects 1,0,1,0,0. Each bit lasts N chips (default 31), and the first bit starts at the first chip after reset.
- R6: `tx_chip` equals the current data bit XOR `pn_chip`.
- R7: After the receiver has consumed the N-th chip of a bit, `rx_valid` is 1 for one cycle and `rx_bit` is 1 exactly when at least (N+1)/2 of those despread chips were 1. `rx_bit` changes only together with `rx_valid`.
- R8: With `rx_chip` fed from `tx_chip` and `rx_offset`=0, the recovered bits equal the selected pattern in order.
- R9: With `rx_offset`=k, the receiver ignores the first k enabled chips and then despreads chip k+j with receive PN chip j. For any k from 1 to 30, at least one recovered bit differs from the pattern.
- R10: With offset 0, flipping up to (N-1)/2 chips of each bit leaves the recovered bits correct. Flipping (N+1)/2 chips of each bit inverts every recovered bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | Chip-rate enable; one chip per high cycle |
| pat_sel | input | 1 | Data pattern choice (0 or 1) |
| tx_chip | output | 1 | Spread chip output |
| pn_chip | output | 1 | Current transmit PN chip |
| rx_chip | input | 1 | Received chip |
| rx_offset | input | 5 | Receiver start delay in chips |
| rx_bit | output | 1 | Recovered data bit |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_bit` |

## Verification
Two things can meet on the same edge. The receiver closes one bit's majority vote and also accumulates the first chip of the next bit. On the transmit side, the PN period wraps at the same moment the data bit changes. The bench provokes both by holding `chip_en` high without gaps across every bit boundary for all 31 offsets. It repeats the runs with sparse enables so that idle edges fall next to those boundaries. Each recovered bit is judged against a chip-by-chip arithmetic count built from the stated recurrence, and each transmitted chip is judged against the same model.

// File: rtl/dsss_pkg.sv
package dsss_pkg;
   typedef enum logic {PAT_FIRST = 1'b0, PAT_SECOND = 1'b1} pat_sel_e;

   function automatic int cnt_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/dsss_pn_gen.sv
module dsss_pn_gen #(
   parameter int          W    = 5,
   parameter logic [W-1:0] TAPS = 5'b10100,
   parameter logic [W-1:0] SEED = 5'b10011
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic chip
);
   logic [W-1:0] state_q;
   logic         fb;

   initial begin
      assert (SEED != '0) else $error("PN seed must be nonzero");
      assert (TAPS[W-1]) else $error("PN taps must include the top stage");
      assert (W >= 2) else $error("PN register needs two stages");
   end

   assign fb   = ^(state_q & TAPS);
   assign chip = state_q[W-1];

   always_ff @(posedge clk) begin
      if (!rst_n)                state_q <= SEED;
      else if (state_q == '0)    state_q <= SEED;
      else if (step)             state_q <= {state_q[W-2:0], fb};
   end
endmodule

// File: rtl/dsss_spreader.sv
module dsss_spreader #(
   parameter int                N       = 31,
   parameter int                PAT_LEN = 5,
   parameter logic [PAT_LEN-1:0] PAT_A  = 5'b10000,
   parameter logic [PAT_LEN-1:0] PAT_B  = 5'b10100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chip_en,
   input  logic pat_sel,
   input  logic pn,
   output logic tx_chip
);
   import dsss_pkg::*;
   localparam int CW = cnt_w(N);
   localparam int PW = cnt_w(PAT_LEN);

   logic [PW-1:0]      pos_q;
   logic               bit_end;
   logic [PAT_LEN-1:0] pat_now;
   logic               data_bit;

   generate
      if (N > 1) begin : g_multi
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                              cnt_q <= '0;
            else if (chip_en && cnt_q == CW'(N - 1)) cnt_q <= '0;
            else if (chip_en)                        cnt_q <= cnt_q + 1'b1;
         end
         assign bit_end = chip_en && (cnt_q == CW'(N - 1));
      end else begin : g_single
         assign bit_end = chip_en;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                                   pos_q <= '0;
      else if (bit_end && pos_q == PW'(PAT_LEN - 1)) pos_q <= '0;
      else if (bit_end)                             pos_q <= pos_q + 1'b1;
   end

   assign pat_now  = (pat_sel == PAT_SECOND) ? PAT_B : PAT_A;
   assign data_bit = pat_now[PW'(PAT_LEN - 1) - pos_q];
   assign tx_chip  = data_bit ^ pn;
endmodule

// File: rtl/dsss_despreader.sv
module dsss_despreader #(
   parameter int N     = 31,
   parameter int OFF_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chip_en,
   input  logic             rx_chip,
   input  logic             pn,
   input  logic [OFF_W-1:0] offset,
   output logic             step,
   output logic             bit_out,
   output logic             valid
);
   import dsss_pkg::*;
   localparam int CW = cnt_w(N);
   localparam int AW = $clog2(N + 1);
   localparam logic [AW-1:0] TH = AW'((N + 1) / 2);

   logic [OFF_W-1:0] skip_q;
   logic             active;
   logic [CW-1:0]    cnt_q;
   logic [AW-1:0]    acc_q;
   logic [AW-1:0]    sum;
   logic             last;

   initial assert (N % 2 == 1) else $error("chips per bit must be odd");

   assign active = (skip_q >= offset);
   assign step   = chip_en && active;
   assign sum    = acc_q + AW'(rx_chip ^ pn);
   assign last   = (N == 1) || (cnt_q == CW'(N - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)                 skip_q <= '0;
      else if (chip_en && !active) skip_q <= skip_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         acc_q   <= '0;
         bit_out <= 1'b0;
         valid   <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (step) begin
            if (last) begin
               bit_out <= (sum >= TH);
               valid   <= 1'b1;
               acc_q   <= '0;
               cnt_q   <= '0;
            end else begin
               acc_q <= sum;
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dsss_codec.sv
module dsss_codec #(
   parameter int                  LFSR_W  = 5,
   parameter logic [LFSR_W-1:0]   TAPS    = 5'b10100,
   parameter logic [LFSR_W-1:0]   SEED    = 5'b10011,
   parameter int                  N       = 31,
   parameter int                  PAT_LEN = 5,
   parameter logic [PAT_LEN-1:0]  PAT_A   = 5'b10000,
   parameter logic [PAT_LEN-1:0]  PAT_B   = 5'b10100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_en,
   input  logic              pat_sel,
   output logic              tx_chip,
   output logic              pn_chip,
   input  logic              rx_chip,
   input  logic [LFSR_W-1:0] rx_offset,
   output logic              rx_bit,
   output logic              rx_valid
);
   logic rx_pn;
   logic rx_step;

   dsss_pn_gen #(.W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) tx_pn_i (
      .clk(clk), .rst_n(rst_n), .step(chip_en), .chip(pn_chip));

   dsss_spreader #(.N(N), .PAT_LEN(PAT_LEN), .PAT_A(PAT_A), .PAT_B(PAT_B)) spread_i (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .pat_sel(pat_sel),
      .pn(pn_chip), .tx_chip(tx_chip));

   dsss_pn_gen #(.W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) rx_pn_i (
      .clk(clk), .rst_n(rst_n), .step(rx_step), .chip(rx_pn));

   dsss_despreader #(.N(N), .OFF_W(LFSR_W)) despread_i (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .rx_chip(rx_chip),
      .pn(rx_pn), .offset(rx_offset), .step(rx_step),
      .bit_out(rx_bit), .valid(rx_valid));
endmodule

// File: rtl/dsss_codec_chk.sv
module dsss_codec_chk #(
   parameter int LFSR_W = 5,
   parameter int N      = 31
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chip_en,
   input logic              pn_chip,
   input logic              rx_bit,
   input logic              rx_valid,
   input logic [LFSR_W-1:0] tx_state
);
   localparam int PN_LEN = (1 << LFSR_W) - 1;
   localparam int CW     = $clog2(PN_LEN + 1);

   logic [CW-1:0] per_q;
   logic [CW-1:0] ones_q;
   logic          bal_done_q;
   logic [CW-1:0] bal_sum_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_q      <= '0;
         ones_q     <= '0;
         bal_done_q <= 1'b0;
         bal_sum_q  <= '0;
      end else begin
         bal_done_q <= 1'b0;
         if (chip_en) begin
            if (per_q == CW'(PN_LEN - 1)) begin
               bal_done_q <= 1'b1;
               bal_sum_q  <= ones_q + CW'(pn_chip);
               per_q      <= '0;
               ones_q     <= '0;
            end else begin
               per_q  <= per_q + 1'b1;
               ones_q <= ones_q + CW'(pn_chip);
            end
         end
      end
   end

   p_balance_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bal_done_q |-> (bal_sum_q == CW'(1 << (LFSR_W - 1))));

   p_pn_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
      chip_en |=> (pn_chip == $past(tx_state[LFSR_W-2])));

   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_en |=> ($stable(pn_chip) && !rx_valid));

   p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (N > 1 && rx_valid) |=> !rx_valid);

   p_bit_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rx_valid || $stable(rx_bit)));
endmodule

bind dsss_codec dsss_codec_chk #(.LFSR_W(LFSR_W), .N(N)) chk_i (
   .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .pn_chip(pn_chip),
   .rx_bit(rx_bit), .rx_valid(rx_valid), .tx_state(tx_pn_i.state_q));

// File: tb/dsss_codec_tb_top.sv
module dsss_codec_tb_top;
   localparam int N  = 31;
   localparam int PL = 31;
   localparam logic [4:0] SEED = 5'b10011;
   localparam logic [4:0] PA = 5'b10000;
   localparam logic [4:0] PB = 5'b10100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chip_en = 1'b0;
   logic pat_sel = 1'b0;
   logic rx_chip = 1'b0;
   logic [4:0] rx_offset = '0;
   logic tx_chip, pn_chip, rx_bit, rx_valid;

   int n_chk = 0;
   int n_fail = 0;
   logic pn_ref [PL];

   always #2 clk = ~clk;

   dsss_codec dut_i (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .pat_sel(pat_sel),
      .tx_chip(tx_chip), .pn_chip(pn_chip), .rx_chip(rx_chip),
      .rx_offset(rx_offset), .rx_bit(rx_bit), .rx_valid(rx_valid));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic pat_bit(input logic sel, input int p);
      logic [4:0] pt;
      pt = sel ? PB : PA;
      return pt[4 - p];
   endfunction

   task automatic run(input logic sel, input int k, input int flips, input int gap, input int nbits);
      int t, cyc, acc, ones, rxb, mism, total, j;
      logic exp_pend, exp_bit, en, d, fl;
      rst_n = 1'b0; chip_en = 1'b0; pat_sel = sel; rx_offset = 5'(k); rx_chip = 1'b0;
      repeat (2) @(negedge clk);
      chk(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
      chk(rx_bit == 1'b0, "R1 rx_bit", int'(rx_bit), 0);
      chk(pn_chip == SEED[4], "R1 pn_chip", int'(pn_chip), int'(SEED[4]));
      rst_n = 1'b1;
      t = 0; cyc = 0; acc = 0; ones = 0; rxb = 0; mism = 0; exp_pend = 0; exp_bit = 0;
      total = nbits * N + k;
      while (t < total || exp_pend) begin
         @(negedge clk);
         if (exp_pend) begin
            chk(rx_valid == 1'b1, "R7 valid strobe", int'(rx_valid), 1);
            chk(rx_bit == exp_bit, "R7 vote", int'(rx_bit), int'(exp_bit));
            if (k == 0 && flips == 0)
               chk(rx_bit == pat_bit(sel, rxb % 5), "R8 recovered", int'(rx_bit), int'(pat_bit(sel, rxb % 5)));
            if (k == 0 && flips > 0 && flips <= (N - 1) / 2)
               chk(rx_bit == pat_bit(sel, rxb % 5), "R10 tolerated", int'(rx_bit), int'(pat_bit(sel, rxb % 5)));
            if (k == 0 && flips == (N + 1) / 2)
               chk(rx_bit == !pat_bit(sel, rxb % 5), "R10 inverted", int'(rx_bit), int'(!pat_bit(sel, rxb % 5)));
            if (rx_bit != pat_bit(sel, rxb % 5)) mism++;
            rxb++;
            exp_pend = 0;
         end else begin
            chk(rx_valid == 1'b0, "R7 no strobe", int'(rx_valid), 0);
         end
         if (t >= total) begin
            chip_en = 1'b0;
            continue;
         end
         en = (gap == 0) || (cyc % gap != 0);
         cyc++;
         d = pat_bit(sel, (t / N) % 5);
         chk(pn_chip == pn_ref[t % PL], "R2 pn chip", int'(pn_chip), int'(pn_ref[t % PL]));
         chk(tx_chip == (d ^ pn_ref[t % PL]), "R6 R5 tx chip", int'(tx_chip), int'(d ^ pn_ref[t % PL]));
         fl = (flips > 0) && ((t % N) < flips);
         rx_chip = tx_chip ^ fl;
         chip_en = en;
         if (en) begin
            if (t < PL) ones += int'(pn_chip);
            if (t == PL - 1) chk(ones == 16, "R3 balance", ones, 16);
            if (t >= k) begin
               j = t - k;
               acc += int'(rx_chip ^ pn_ref[j % PL]);
               if (j % N == N - 1) begin
                  exp_bit = (acc >= (N + 1) / 2);
                  exp_pend = 1;
                  acc = 0;
               end
            end
            t++;
         end
      end
      chip_en = 1'b0;
      if (k != 0) chk(mism > 0, "R9 misaligned corrupts", mism, 1);
   endtask

   initial begin
      logic [4:0] s;
      s = SEED;
      for (int i = 0; i < PL; i++) begin
         pn_ref[i] = s[4];
         s = {s[3:0], s[4] ^ s[2]};
      end
      for (int ps = 0; ps < 2; ps++)
         for (int k = 0; k < 31; k++)
            run(ps[0], k, 0, 0, 6);
      run(1'b0, 0, 0, 3, 6);   // R4 idle cycles between chips
      run(1'b1, 0, 0, 4, 5);   // R4
      run(1'b0, 0, 15, 3, 6);  // R10 tolerated flips
      run(1'b1, 0, 15, 0, 5);  // R10
      run(1'b1, 0, 16, 0, 5);  // R10 inversion
      run(1'b0, 7, 0, 2, 6);   // R9 with idle cycles
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule